// File: doc/BRIEF.md
# Instruction Count Debug Trigger

This block keeps a 32-bit retired-instruction counter and a 4-bit gating level next to a processor pipeline. Each cycle the pipeline may report one retiring instruction together with the interrupt level that was in force when that instruction began. The counter advances only for instructions whose starting interrupt level is strictly below the stored gating level. Software arms the trigger by loading the counter with a negative value. The counter never passes from all ones to zero. On that step it holds its value and, if the instruction's interrupt level is below the configured debug level, raises a one-cycle debug request tagged with an instruction-count cause bit.

Both registers are reached through a small special-register port: a write port with an address and data, and a separate combinational read port. The counter sits at address 236 and the gating level at 237. A counter write in the same cycle as a counted retire replaces that retire's increment. A wrap step that raises the debug request stands for an instruction that never executes, so any register write carried with it is discarded.

Top module: `icount_trigger`

## Requirements
- R1: After reset the counter and the gating level read as zero, and `dbg_req_o` and `dbg_cause_o` are zero.
- R2: A retire (`retire_valid_i`=1) with `retire_level_i` strictly below the stored gating level adds one to the counter. The new value is readable in the following cycle.
- R3: A retire whose `retire_level_i` is equal to or above the gating level, or a cycle with no retire, leaves the counter unchanged.
- R4: A counted retire while the counter is 32'hFFFFFFFF leaves the counter at 32'hFFFFFFFF. It never becomes zero.
- R5: A counted retire while the counter is all ones, with `retire_level_i` strictly below `dbg_level_i`, drives `dbg_req_o` high for exactly the following cycle. In that cycle `dbg_cause_o` is 6'b000001 (bit 0 is the instruction-count cause). Without such a retire, `dbg_req_o` is 0 and `dbg_cause_o` is zero.
- R6: A register write made in the same cycle as a retire that raises the debug request has no effect on either register.
- R7: A counter write in the same cycle as a counted retire stores the written value instead of the increment.
- R8: A counter write in a cycle without a counted retire stores the written value directly.
- R9: A write to the gating level keeps only bits 3:0 of the data. Reading the level returns it zero-extended to 32 bits.
- R10: The counter is at address 236 and the gating level at 237. Reads of any other address return zero, and writes to any other address change neither register.
- R11: The gating decision for a retire uses the level held before any level write made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| retire_valid_i | input | 1 | One instruction completes this cycle |
| retire_level_i | input | 4 | Interrupt level at the start of that instruction |
| dbg_level_i | input | 4 | Configured debug level |
| sr_we_i | input | 1 | Special-register write enable |
| sr_waddr_i | input | 8 | Write address |
| sr_wdata_i | input | 32 | Write data |
| sr_raddr_i | input | 8 | Read address |
| sr_rdata_o | output | 32 | Committed value at the read address |
| dbg_req_o | output | 1 | Debug exception request pulse |
| dbg_cause_o | output | 6 | Cause vector; bit 0 is the instruction-count cause |

## Verification
The assertions assume that the pipeline reports at most one retire per cycle and that the interrupt and debug levels are stable, known values in the cycle they are sampled. They also assume that a write and a retire in the same cycle belong to the same instruction. The bench changes inputs only at falling edges and never drives unknown values. It compares every cycle against a behavioural model. It loads values just below all ones so that the hold and request path is exercised many times, and it mixes in random level writes so that counting switches on and off.

// File: rtl/icount_pkg.sv
package icount_pkg;
    localparam int CNT_W_DEF    = 32;
    localparam int LVL_W_DEF    = 4;
    localparam int ADDR_W_DEF   = 8;
    localparam int CNT_ADDR_DEF = 236;
    localparam int LVL_ADDR_DEF = 237;
    localparam int CAUSE_W_DEF  = 6;
    localparam int IC_BIT_DEF   = 0;
endpackage

// File: rtl/icount_gate.sv
module icount_gate #(
    parameter int LVL_W = icount_pkg::LVL_W_DEF
) (
    input  logic             retire_valid_i,
    input  logic [LVL_W-1:0] retire_level_i,
    input  logic [LVL_W-1:0] count_level_i,
    input  logic [LVL_W-1:0] dbg_level_i,
    output logic             count_en_o,
    output logic             dbg_ok_o
);
    always_comb begin
        count_en_o = retire_valid_i && (retire_level_i < count_level_i);
        dbg_ok_o   = retire_level_i < dbg_level_i;
    end
endmodule

// File: rtl/icount_step.sv
module icount_step #(
    parameter int CNT_W = icount_pkg::CNT_W_DEF
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             count_en_i,
    input  logic             dbg_ok_i,
    output logic [CNT_W-1:0] cnt_next_o,
    output logic             exc_o
);
    logic at_top;

    always_comb begin
        at_top     = &cnt_i;
        cnt_next_o = (count_en_i && !at_top) ? cnt_i + CNT_W'(1) : cnt_i;
        exc_o      = count_en_i && at_top && dbg_ok_i;
    end
endmodule

// File: rtl/icount_sr_port.sv
module icount_sr_port #(
    parameter int ADDR_W   = icount_pkg::ADDR_W_DEF,
    parameter int CNT_W    = icount_pkg::CNT_W_DEF,
    parameter int LVL_W    = icount_pkg::LVL_W_DEF,
    parameter int CNT_ADDR = icount_pkg::CNT_ADDR_DEF,
    parameter int LVL_ADDR = icount_pkg::LVL_ADDR_DEF
) (
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [ADDR_W-1:0] raddr_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [LVL_W-1:0]  lvl_i,
    output logic              wr_cnt_o,
    output logic              wr_lvl_o,
    output logic [CNT_W-1:0]  rdata_o
);
    localparam logic [ADDR_W-1:0] CntSel = ADDR_W'(CNT_ADDR);
    localparam logic [ADDR_W-1:0] LvlSel = ADDR_W'(LVL_ADDR);

    always_comb begin
        wr_cnt_o = we_i && (waddr_i == CntSel);
        wr_lvl_o = we_i && (waddr_i == LvlSel);
        if (raddr_i == CntSel)      rdata_o = cnt_i;
        else if (raddr_i == LvlSel) rdata_o = {{(CNT_W-LVL_W){1'b0}}, lvl_i};
        else                        rdata_o = '0;
    end
endmodule

// File: rtl/icount_trigger.sv
module icount_trigger #(
    parameter int CNT_W    = icount_pkg::CNT_W_DEF,
    parameter int LVL_W    = icount_pkg::LVL_W_DEF,
    parameter int ADDR_W   = icount_pkg::ADDR_W_DEF,
    parameter int CNT_ADDR = icount_pkg::CNT_ADDR_DEF,
    parameter int LVL_ADDR = icount_pkg::LVL_ADDR_DEF,
    parameter int CAUSE_W  = icount_pkg::CAUSE_W_DEF,
    parameter int IC_BIT   = icount_pkg::IC_BIT_DEF
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               retire_valid_i,
    input  logic [LVL_W-1:0]   retire_level_i,
    input  logic [LVL_W-1:0]   dbg_level_i,
    input  logic               sr_we_i,
    input  logic [ADDR_W-1:0]  sr_waddr_i,
    input  logic [CNT_W-1:0]   sr_wdata_i,
    input  logic [ADDR_W-1:0]  sr_raddr_i,
    output logic [CNT_W-1:0]   sr_rdata_o,
    output logic               dbg_req_o,
    output logic [CAUSE_W-1:0] dbg_cause_o
);
    localparam logic [CNT_W-1:0] AllOnes = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [LVL_W-1:0] lvl;
        logic             req;
    } state_t;

    state_t st_d, st_q;

    logic             count_en, dbg_ok, exc;
    logic             wr_cnt, wr_lvl;
    logic [CNT_W-1:0] cnt_step;

    icount_gate #(.LVL_W(LVL_W)) gate_i (
        .retire_valid_i (retire_valid_i),
        .retire_level_i (retire_level_i),
        .count_level_i  (st_q.lvl),
        .dbg_level_i    (dbg_level_i),
        .count_en_o     (count_en),
        .dbg_ok_o       (dbg_ok)
    );

    icount_step #(.CNT_W(CNT_W)) step_i (
        .cnt_i      (st_q.cnt),
        .count_en_i (count_en),
        .dbg_ok_i   (dbg_ok),
        .cnt_next_o (cnt_step),
        .exc_o      (exc)
    );

    icount_sr_port #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LVL_W(LVL_W),
        .CNT_ADDR(CNT_ADDR), .LVL_ADDR(LVL_ADDR)
    ) port_i (
        .we_i     (sr_we_i),
        .waddr_i  (sr_waddr_i),
        .raddr_i  (sr_raddr_i),
        .cnt_i    (st_q.cnt),
        .lvl_i    (st_q.lvl),
        .wr_cnt_o (wr_cnt),
        .wr_lvl_o (wr_lvl),
        .rdata_o  (sr_rdata_o)
    );

    // Next state: the increment first, then an SR write unless the
    // instruction was pre-empted by the debug request.
    always_comb begin
        st_d     = st_q;
        st_d.cnt = cnt_step;
        st_d.req = exc;
        if (wr_cnt && !exc) st_d.cnt = sr_wdata_i;
        if (wr_lvl && !exc) st_d.lvl = sr_wdata_i[LVL_W-1:0];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign dbg_req_o = st_q.req;

    for (genvar gi = 0; gi < CAUSE_W; gi++) begin : g_cause
        if (gi == IC_BIT) begin : g_ic
            assign dbg_cause_o[gi] = st_q.req;
        end else begin : g_other
            assign dbg_cause_o[gi] = 1'b0;
        end
    end

    AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count_en && !sr_we_i && st_q.cnt != AllOnes) |=> (st_q.cnt == $past(st_q.cnt) + CNT_W'(1))); // R2

    AST_GATED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!(retire_valid_i && retire_level_i < st_q.lvl) && !sr_we_i) |=> $stable(st_q.cnt)); // R3

    AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (retire_valid_i && retire_level_i < st_q.lvl && st_q.cnt == AllOnes && !sr_we_i) |=> (st_q.cnt == AllOnes)); // R4

    AST_REQ_NEEDS_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dbg_req_o |-> $past(retire_valid_i && retire_level_i < dbg_level_i)); // R5

    AST_REQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dbg_req_o |-> (dbg_cause_o[IC_BIT] && $onehot0(dbg_cause_o))); // R5

    AST_EXC_DROPS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc |=> ($stable(st_q.cnt) && $stable(st_q.lvl))); // R6

    AST_LVL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_lvl && !exc) |=> (st_q.lvl == $past(sr_wdata_i[LVL_W-1:0]))); // R9
endmodule

// File: tb/icount_trigger_tb.sv
module icount_trigger_tb_top;
    localparam int CA = 236;
    localparam int LA = 237;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rv = 1'b0;
    logic [3:0]  rl = '0, dl = '0;
    logic        we = 1'b0;
    logic [7:0]  wa = '0, ra = '0;
    logic [31:0] wd = '0;
    logic [31:0] rdata;
    logic        req;
    logic [5:0]  cause;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_cnt = '0;
    logic [3:0]  m_lvl = '0;
    logic        m_req = 1'b0;

    always #4 clk = ~clk;

    icount_trigger dut_i (
        .clk_i(clk), .rst_ni(rst_n), .retire_valid_i(rv), .retire_level_i(rl),
        .dbg_level_i(dl), .sr_we_i(we), .sr_waddr_i(wa), .sr_wdata_i(wd),
        .sr_raddr_i(ra), .sr_rdata_o(rdata), .dbg_req_o(req), .dbg_cause_o(cause)
    );

    function automatic logic [31:0] m_read(logic [7:0] a);
        if (a == 8'(CA)) return m_cnt;
        if (a == 8'(LA)) return {28'd0, m_lvl};
        return 32'd0;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_step();
        logic        en, exc;
        logic [31:0] nxt;
        en  = rv && (rl < m_lvl);
        exc = 1'b0;
        nxt = m_cnt;
        if (en) begin
            if (m_cnt == 32'hFFFF_FFFF) exc = (rl < dl);
            else nxt = m_cnt + 1;
        end
        if (we && !exc) begin
            if (wa == 8'(CA)) nxt = wd;
            if (wa == 8'(LA)) m_lvl = wd[3:0];
        end
        m_cnt = nxt;
        m_req = exc;
    endtask

    task automatic compare(string tag);
        chk(tag, "rdata", rdata, m_read(ra));
        chk(tag, "req", {31'd0, req}, {31'd0, m_req});
        chk(tag, "cause", {26'd0, cause}, m_req ? 32'd1 : 32'd0);
    endtask

    // One cycle: drive at the falling edge, model at the rising edge,
    // compare at the next falling edge.
    task automatic cyc(string tag, logic v, logic [3:0] l, logic [3:0] d,
                       logic w, logic [7:0] a, logic [31:0] data, logic [7:0] r);
        rv = v; rl = l; dl = d; we = w; wa = a; wd = data; ra = r;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(string tag, logic [7:0] r);
        cyc(tag, 1'b0, 4'd0, 4'd0, 1'b0, 8'd0, 32'd0, r);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        ra = 8'(CA);
        #1;
        chk("R1", "cnt after reset", rdata, 32'd0);
        chk("R1", "req after reset", {31'd0, req}, 32'd0);
        idle("R1", 8'(LA));
        // R3: level zero keeps counting off
        cyc("R3", 1'b1, 4'd0, 4'd0, 1'b0, 8'd0, 32'd0, 8'(CA));
        // R9: only low bits kept
        cyc("R9", 1'b0, 4'd0, 4'd0, 1'b1, 8'(LA), 32'hFFFF_FFF5, 8'(LA));
        chk("R9", "level zero-extended", rdata, 32'd5);
        // R2: counted retires
        for (int i = 0; i < 4; i++)
            cyc("R2", 1'b1, 4'd2, 4'd0, 1'b0, 8'd0, 32'd0, 8'(CA));
        chk("R2", "four increments", rdata, 32'd4);
        // R3: equal or above level
        cyc("R3", 1'b1, 4'd5, 4'd0, 1'b0, 8'd0, 32'd0, 8'(CA));
        cyc("R3", 1'b1, 4'd9, 4'd0, 1'b0, 8'd0, 32'd0, 8'(CA));
        chk("R3", "no count at/above level", rdata, 32'd4);
        // R7: write replaces increment
        cyc("R7", 1'b1, 4'd1, 4'd0, 1'b1, 8'(CA), 32'h1234_0000, 8'(CA));
        chk("R7", "write wins", rdata, 32'h1234_0000);
        // R8: write while not counting
        cyc("R8", 1'b1, 4'd7, 4'd0, 1'b1, 8'(CA), 32'hFFFF_FFFE, 8'(CA));
        chk("R8", "direct store", rdata, 32'hFFFF_FFFE);
        cyc("R2", 1'b1, 4'd0, 4'd8, 1'b0, 8'd0, 32'd0, 8'(CA));
        chk("R2", "reach all ones", rdata, 32'hFFFF_FFFF);
        // R4 R5 R6: wrap step with request, carried write dropped
        cyc("R6", 1'b1, 4'd2, 4'd8, 1'b1, 8'(CA), 32'd7, 8'(CA));
        chk("R4", "held at all ones", rdata, 32'hFFFF_FFFF);
        chk("R5", "request pulse", {31'd0, req}, 32'd1);
        chk("R5", "cause bit", {26'd0, cause}, 32'd1);
        idle("R5", 8'(CA));
        chk("R5", "pulse ends", {31'd0, req}, 32'd0);
        // R5: level not below debug level -> no request, still held
        cyc("R5", 1'b1, 4'd4, 4'd4, 1'b0, 8'd0, 32'd0, 8'(CA));
        idle("R5", 8'(CA));
        chk("R4", "held without request", rdata, 32'hFFFF_FFFF);
        // R10: foreign address
        cyc("R10", 1'b0, 4'd0, 4'd0, 1'b1, 8'd238, 32'd0, 8'd238);
        chk("R10", "foreign read zero", rdata, 32'd0);
        idle("R10", 8'(CA));
        chk("R10", "foreign write ignored", rdata, 32'hFFFF_FFFF);
        // R11: old level gates the same-cycle retire
        cyc("R8", 1'b0, 4'd0, 4'd0, 1'b1, 8'(CA), 32'd100, 8'(CA));
        cyc("R11", 1'b1, 4'd3, 4'd0, 1'b1, 8'(LA), 32'd1, 8'(CA));
        chk("R11", "counted with old level", rdata, 32'd101);
        cyc("R11", 1'b1, 4'd3, 4'd0, 1'b0, 8'd0, 32'd0, 8'(CA));
        chk("R11", "new level gates", rdata, 32'd101);
        // Random mix near the wrap point
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] rnd;
            logic [7:0]  a;
            logic        w;
            rnd = $urandom;
            w   = (rnd[3:0] == 4'd0);
            a   = rnd[4] ? 8'(LA) : 8'(CA);
            if (i % 50 == 0) begin
                w = 1'b1; a = 8'(CA);
            end
            cyc("R2", rnd[5], 4'(rnd[8:6]), 4'(rnd[11:9]), w, a,
                (a == 8'(CA)) ? (32'hFFFF_FFF0 | 32'(rnd[15:12])) : $urandom,
                rnd[16] ? 8'(LA) : 8'(CA));
        end
        summary();
    end
endmodule